// File: doc/BRIEF.md
# Character Display Output Port

This block is the device side of a character display attached to a 16-bit processor bus. It holds two registers at fixed word addresses. The first is a status register that carries a ready flag and an interrupt-enable bit. The second is a data register that accepts one 8-bit character. Software polls the ready flag, or waits for the interrupt, and then stores the next character into the data register.

A store that arrives while the port is ready latches the character and clears ready. The port then hands the character to the display sink with a single-cycle valid pulse. Ready stays low until the sink answers with a done pulse, which may come any number of cycles later. Character stores made while ready is low are dropped without any trace. The interrupt request is raised whenever ready and the enable bit are both set.

The address decoder has two jobs. It produces the load enable for the character register, and it picks the read source. The read path is combinational by default. A parameter can add a register stage to it instead.

Top module: `dispout_port`

## Requirements
- R1: After reset, ready is 1, interrupt-enable is 0, the held character is 0x00, `disp_valid` is 0 and `irq` is 0.
- R2: A read (`bus_rd`=1) at word address 0xFE04 returns ready in bit 15 and interrupt-enable in bit 14, with every other bit 0.
- R3: A write to 0xFE06 while ready is 1 latches `bus_wdata[7:0]` onto `disp_char` and reads ready as 0 from the next cycle.
- R4: A write to 0xFE06 while ready is 0 has no effect: `disp_char` keeps its value and no `disp_valid` pulse follows.
- R5: `disp_valid` is 1 for exactly the one cycle after a character is latched and is 0 otherwise.
- R6: A `disp_done` pulse while ready is 0 sets ready from the next cycle. A done while ready is 1 leaves it at 1. A done in the same cycle as an accepted character write loses, so ready goes to 0.
- R7: A write to 0xFE04 sets interrupt-enable to `bus_wdata[14]`. Bit 15 of that write does not change ready.
- R8: `irq` is 1 exactly when ready and interrupt-enable are both 1.
- R9: A read at 0xFE06 returns the held character in bits [7:0], with bits [15:8] zero.
- R10: A read at any other address, or with `bus_rd`=0, returns 0. A write to any other address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Word address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of `bus_rd` |
| disp_char | output | 8 | Character presented to the display sink |
| disp_valid | output | 1 | One-cycle strobe: `disp_char` holds a new character |
| disp_done | input | 1 | Sink pulse: the previous character is finished |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the port with its default parameters: the two addresses 0xFE04 and 0xFE06, an 8-bit character, and the combinational read path. Because reads are combinational, every status and data value can be compared in the same cycle as the strobe. A behavioural sink answers each character after five cycles. That delay opens a busy window long enough to aim dropped writes, status reads and enable changes into it. The bench also forces done pulses by hand. This reaches the stray done while ready and the done that collides with an accepted write.

// File: rtl/dispout_pkg.sv
package dispout_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_STAT = 2'd1,
      SEL_DATA = 2'd2
   } dsel_e;

   function automatic logic [15:0] pack_status(input logic rdy, input logic en,
                                               input int rdy_pos, input int en_pos);
      logic [15:0] w;
      w = '0;
      w[rdy_pos] = rdy;
      w[en_pos]  = en;
      return w;
   endfunction

endpackage

// File: rtl/dispout_decode.sv
module dispout_decode
   import dispout_pkg::*;
#(
   parameter int              ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE06
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic              ready,
   output dsel_e             rd_sel,
   output logic              stat_we,
   output logic              data_ld
);
   logic hit_stat;
   logic hit_data;

   assign hit_stat = (addr == STAT_ADDR);
   assign hit_data = (addr == DATA_ADDR);

   always_comb begin
      rd_sel = SEL_NONE;
      if (rd && hit_stat)      rd_sel = SEL_STAT;
      else if (rd && hit_data) rd_sel = SEL_DATA;
   end

   assign stat_we = wr & hit_stat;
   assign data_ld = wr & hit_data & ready;

endmodule

// File: rtl/dispout_status.sv
module dispout_status (
   input  logic clk,
   input  logic rst_n,
   input  logic stat_we,
   input  logic en_in,
   input  logic data_ld,
   input  logic done,
   output logic ready,
   output logic ie,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready <= 1'b1;
      end else if (data_ld) begin
         ready <= 1'b0;
      end else if (done) begin
         ready <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie <= 1'b0;
      end else if (stat_we) begin
         ie <= en_in;
      end
   end

   assign irq = ready & ie;

endmodule

// File: rtl/dispout_charreg.sv
module dispout_charreg #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_ld,
   input  logic [CHAR_W-1:0] din,
   output logic [CHAR_W-1:0] char_q,
   output logic              valid_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         char_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= data_ld;
         if (data_ld) char_q <= din;
      end
   end

endmodule

// File: rtl/dispout_port.sv
module dispout_port
   import dispout_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 16,
   parameter int                CHAR_W    = 8,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE06,
   parameter int                RDY_POS   = 15,
   parameter int                EN_POS    = 14,
   parameter bit                RD_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [CHAR_W-1:0] disp_char,
   output logic              disp_valid,
   input  logic              disp_done,
   output logic              irq
);
   localparam int PAD_W = DATA_W - CHAR_W;

   if (CHAR_W > DATA_W || CHAR_W < 1) begin : g_bad_char
      $error("dispout_port: CHAR_W must be 1..DATA_W");
   end
   if (DATA_W != 16) begin : g_bad_data
      $error("dispout_port: status packing assumes a 16-bit word");
   end
   if (RDY_POS == EN_POS || RDY_POS >= DATA_W || EN_POS >= DATA_W) begin : g_bad_pos
      $error("dispout_port: status bit positions invalid");
   end
   if (STAT_ADDR == DATA_ADDR) begin : g_bad_addr
      $error("dispout_port: register addresses collide");
   end

   dsel_e             rd_sel;
   logic              stat_we;
   logic              data_ld;
   logic              ready_q;
   logic              ie_q;
   logic [CHAR_W-1:0] char_q;
   logic [DATA_W-1:0] rd_mux;

   dispout_decode #(
      .ADDR_W   (ADDR_W),
      .STAT_ADDR(STAT_ADDR),
      .DATA_ADDR(DATA_ADDR)
   ) u_dec (
      .addr   (bus_addr),
      .wr     (bus_wr),
      .rd     (bus_rd),
      .ready  (ready_q),
      .rd_sel (rd_sel),
      .stat_we(stat_we),
      .data_ld(data_ld)
   );

   dispout_status u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .stat_we(stat_we),
      .en_in  (bus_wdata[EN_POS]),
      .data_ld(data_ld),
      .done   (disp_done),
      .ready  (ready_q),
      .ie     (ie_q),
      .irq    (irq)
   );

   dispout_charreg #(.CHAR_W(CHAR_W)) u_chr (
      .clk    (clk),
      .rst_n  (rst_n),
      .data_ld(data_ld),
      .din    (bus_wdata[CHAR_W-1:0]),
      .char_q (char_q),
      .valid_q(disp_valid)
   );

   assign disp_char = char_q;

   always_comb begin
      unique case (rd_sel)
         SEL_STAT: rd_mux = pack_status(ready_q, ie_q, RDY_POS, EN_POS);
         SEL_DATA: rd_mux = {{PAD_W{1'b0}}, char_q};
         default:  rd_mux = '0;
      endcase
   end

   if (RD_REG) begin : g_rd_flop
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata_q <= '0;
         else        rdata_q <= rd_mux;
      end
      assign bus_rdata = rdata_q;
   end else begin : g_rd_comb
      assign bus_rdata = rd_mux;
   end

endmodule

// File: rtl/dispout_port_chk.sv
module dispout_port_chk #(
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 16,
   parameter int                CHAR_W    = 8,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE06,
   parameter int                EN_POS    = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [CHAR_W-1:0] disp_char,
   input logic              disp_valid,
   input logic              disp_done,
   input logic              irq,
   input logic              ready,
   input logic              ie
);
   logic acc_ld;
   assign acc_ld = bus_wr && (bus_addr == DATA_ADDR) && ready;

   p_clear_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ld |=> !ready);

   p_char_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ld |=> disp_char == $past(bus_wdata[CHAR_W-1:0]));

   p_drop_when_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DATA_ADDR && !ready) |=> ($stable(disp_char) && !disp_valid));

   p_valid_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_ld |=> disp_valid);

   p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |=> !disp_valid);

   p_done_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_done && !acc_ld) |=> ready);

   p_en_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == STAT_ADDR) |=> ie == $past(bus_wdata[EN_POS]));

   p_irq_needs_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ready && ie));

endmodule

bind dispout_port dispout_port_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .CHAR_W   (CHAR_W),
   .STAT_ADDR(STAT_ADDR),
   .DATA_ADDR(DATA_ADDR),
   .EN_POS   (EN_POS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .disp_char (disp_char),
   .disp_valid(disp_valid),
   .disp_done (disp_done),
   .irq       (irq),
   .ready     (ready_q),
   .ie        (ie_q)
);

// File: tb/dispout_port_test.sv
module dispout_port_test;
   localparam int SINK_LAT = 5;
   localparam logic [15:0] A_STAT = 16'hFE04;
   localparam logic [15:0] A_DATA = 16'hFE06;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [7:0]  disp_char;
   logic        disp_valid;
   logic        disp_done = 1'b0;
   logic        irq;

   int tests = 0;
   int fails = 0;

   // reference state
   bit       m_ready = 1'b1;
   bit       m_ie    = 1'b0;
   bit [7:0] m_char  = '0;
   bit       m_valid = 1'b0;
   int       sink_cd = 0;
   bit [7:0] sent_q[$];

   always #10 clk = ~clk;

   dispout_port uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .disp_char(disp_char), .disp_valid(disp_valid), .disp_done(disp_done),
      .irq(irq)
   );

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_rdata(input logic rd, input logic [15:0] a);
      if (!rd) return 16'h0000;
      if (a == A_STAT) return {m_ready, m_ie, 14'h0};
      if (a == A_DATA) return {8'h00, m_char};
      return 16'h0000;
   endfunction

   // one bus cycle: drive after negedge, compare, then advance the model at posedge
   task automatic step(input string req, input logic wr, input logic rd,
                       input logic [15:0] a, input logic [15:0] wd,
                       input logic force_done);
      bit auto_done;
      bit ld;
      auto_done = (sink_cd == 1);
      if (sink_cd > 0) sink_cd--;
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
      disp_done = auto_done | force_done;
      #1;
      check(req, "rdata", bus_rdata, exp_rdata(rd, a));
      check("R8", "irq", {15'h0, irq}, {15'h0, m_ready & m_ie});
      check("R5", "valid", {15'h0, disp_valid}, {15'h0, m_valid});
      check(req, "char", {8'h0, disp_char}, {8'h0, m_char});
      if (m_valid) sink_cd = SINK_LAT;
      ld = wr && a == A_DATA && m_ready;
      @(posedge clk);
      if (ld) begin
         m_ready = 1'b0;
         m_char = wd[7:0];
         sent_q.push_back(wd[7:0]);
      end else if (disp_done) begin
         m_ready = 1'b1;
      end
      if (wr && a == A_STAT) m_ie = wd[14];
      m_valid = ld;
      @(negedge clk);
   endtask

   task automatic idle(input string req, input int n);
      for (int i = 0; i < n; i++) step(req, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      step("R1", 1'b0, 1'b1, A_STAT, 16'h0, 1'b0);
      check("R1", "status after reset", bus_rdata, 16'h8000);
      step("R1", 1'b0, 1'b1, A_DATA, 16'h0, 1'b0);
      // R7: enable with bit15=0 in write must not clear ready
      step("R7", 1'b1, 1'b0, A_STAT, 16'h4000, 1'b0);
      step("R2", 1'b0, 1'b1, A_STAT, 16'h0, 1'b0);
      check("R2", "status ready+en", bus_rdata, 16'hC000);
      check("R8", "irq both set", {15'h0, irq}, 16'h0001);
      // R3: accepted character
      step("R3", 1'b1, 1'b0, A_DATA, 16'hAB41, 1'b0);
      check("R5", "valid pulse", {15'h0, disp_valid}, 16'h0001);
      check("R3", "char latched", {8'h0, disp_char}, 16'h0041);
      // R4: write while busy dropped
      step("R4", 1'b1, 1'b0, A_DATA, 16'h0042, 1'b0);
      check("R4", "no pulse on drop", {15'h0, disp_valid}, 16'h0000);
      step("R9", 1'b0, 1'b1, A_DATA, 16'h0, 1'b0);
      check("R9", "data read", bus_rdata, 16'h0041);
      step("R2", 1'b0, 1'b1, A_STAT, 16'h0, 1'b0);
      check("R2", "busy status", bus_rdata, 16'h4000);
      // R7: write bit15=1 while busy does not set ready
      step("R7", 1'b1, 1'b0, A_STAT, 16'hC000, 1'b0);
      step("R7", 1'b0, 1'b1, A_STAT, 16'h0, 1'b0);
      check("R7", "ready not writable", bus_rdata, 16'h4000);
      idle("R6", SINK_LAT + 2);
      step("R6", 1'b0, 1'b1, A_STAT, 16'h0, 1'b0);
      check("R6", "ready after done", bus_rdata, 16'hC000);
      // R6: stray done while ready
      step("R6", 1'b0, 1'b0, 16'h0, 16'h0, 1'b1);
      step("R6", 1'b0, 1'b1, A_STAT, 16'h0, 1'b0);
      // R6/R3: done colliding with accepted write
      step("R6", 1'b1, 1'b0, A_DATA, 16'h0043, 1'b1);
      step("R6", 1'b0, 1'b1, A_STAT, 16'h0, 1'b0);
      check("R6", "write beats done", bus_rdata, 16'h4000);
      idle("R6", SINK_LAT + 2);
      // R10: other addresses
      step("R10", 1'b1, 1'b0, 16'hFE08, 16'h0000, 1'b0);
      step("R10", 1'b1, 1'b0, 16'hFE05, 16'h0000, 1'b0);
      step("R10", 1'b0, 1'b1, 16'hFE08, 16'h0, 1'b0);
      check("R10", "unmapped read", bus_rdata, 16'h0000);
      step("R10", 1'b0, 1'b0, A_STAT, 16'h0, 1'b0);
      check("R10", "no strobe read", bus_rdata, 16'h0000);
      // enable off, irq must drop
      step("R7", 1'b1, 1'b0, A_STAT, 16'h8000, 1'b0);
      check("R8", "irq off", {15'h0, irq}, 16'h0000);
      // polled stream of characters
      for (int k = 0; k < 6; k++) begin
         int guard = 0;
         while (!m_ready && guard < 50) begin
            step("R2", 1'b0, 1'b1, A_STAT, 16'h0, 1'b0);
            guard++;
         end
         step("R3", 1'b1, 1'b0, A_DATA, 16'h0060 + 16'(k), 1'b0);
         step("R4", 1'b1, 1'b0, A_DATA, 16'h007F, 1'b0);
      end
      idle("R5", SINK_LAT + 2);
      check("R3", "chars sent", 16'(sent_q.size()), 16'd8);
      check("R9", "last char", {8'h0, disp_char}, 16'h0065);
      finish_run();
   end
endmodule